// File: doc/BRIEF.md
# GPIO Port Controller with Atomic Bit Aliases

This block controls one general-purpose I/O port of up to `NPINS` pins through a plain register bus: an address, a write strobe, write data and a combinational read-data return. It keeps per-pin state for direction, output latch, open-drain mode, digital/analog selection, change-notification enable and pull-up enable. From that state it drives the pad controls every cycle. Pad inputs are brought in through a two-flop synchronizer. The synchronized value is used both for the port-value read and for change detection, which raises a level interrupt for enabled digital pins.

The address is split into two fields. `addr[5:2]` selects a register and `addr[1:0]` selects an access kind. An access is either a plain write, or a masked clear, set or invert that changes only the bits written as 1. Software can therefore flip single pins without a read-modify-write sequence. The register bus is a control path with no flow control: every strobe is accepted in the cycle it is presented. The parameter `IMPL_MASK` marks which pins exist. Bits for missing pins stay zero throughout the block.

Top module: `gpio_port`

## Requirements
- R1: After reset, every direction bit is 1 (input), so `pad_oe` is all zero. The latch, open-drain, digital-select, notify-enable, pull-up and pending registers are zero, and `irq` is low.
- R2: Register select `addr[5:2]` uses these codes: 0 direction, 1 latch, 2 port value, 3 open-drain, 4 digital select, 5 notify enable, 6 pull-up, 7 pending. A write with `addr[1:0]`=00 loads the register, and a read with 00 returns its value.
- R3: With `addr[1:0]` = 01 the write clears, with 10 it sets and with 11 it inverts the register bits whose data bit is 1. Bits written as 0 keep their value.
- R4: A read with `addr[1:0]` other than 00 returns zero.
- R5: Writes of any kind to the port-value register act on the output latch. Reading the latch returns the value it holds.
- R6: Reading the port-value register returns the pad inputs through two synchronizer stages. A pad change is visible after the second rising edge and not after the first.
- R7: A pin whose digital-select bit is 0 (analog) reads 0 in the port-value register.
- R8: A pin whose direction bit is 0 drives `pad_oe`=1 and `pad_out`=latch. When its open-drain bit is 1, a latch value of 1 deasserts `pad_oe` and the pin drives only low.
- R9: Pins outside `IMPL_MASK` read as zero, ignore writes and keep every pad output at zero.
- R10: A change in the synchronized level of a pin that is implemented, digital and notify-enabled sets that pin's pending bit one edge later. `irq` is high while any pending bit is set and stays high until the pin is cleared.
- R11: A clear-kind write (`addr` = 7, kind 01) clears the pending bits written as 1. A pending set in the same cycle takes priority.
- R12: `pad_od` carries the open-drain bits and `pad_pu` carries the pull-up bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe |
| addr | input | 6 | Register select [5:2], access kind [1:0] |
| wdata | input | NPINS | Write data / bit mask |
| rdata | output | NPINS | Read data (combinational from addr) |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Output level to pads |
| pad_oe | output | NPINS | Output enable to pads |
| pad_od | output | NPINS | Open-drain mode to pads |
| pad_pu | output | NPINS | Pull-up enable to pads |
| irq | output | 1 | Change-notification interrupt |

## Verification
Register writes take effect on the rising edge that samples the strobe. The bench therefore reads back, and checks the pad controls, at the following falling edge, because `rdata` and the pad outputs follow the registers without any further flop. A pad change is sampled at falling edges after the first and after the second rising edge, to confirm the two-stage delay. The pending bit and `irq` are expected after the third edge: two synchronizer stages, then the pending flop. All checks therefore sample mid-cycle at falling edges, never at the active edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 6;
  localparam int NSTORE = 6;  // plain storage registers

  typedef enum logic [3:0] {
    RG_DIR  = 4'd0,
    RG_LAT  = 4'd1,
    RG_PIN  = 4'd2,
    RG_ODE  = 4'd3,
    RG_DIG  = 4'd4,
    RG_CNE  = 4'd5,
    RG_PUE  = 4'd6,
    RG_PEND = 4'd7
  } reg_id_t;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_CLR = 2'd1,
    OP_SET = 2'd2,
    OP_INV = 2'd3
  } acc_op_t;

  // storage slot -> register id
  function automatic reg_id_t slot_id(input int k);
    case (k)
      0:       slot_id = RG_DIR;
      1:       slot_id = RG_LAT;
      2:       slot_id = RG_ODE;
      3:       slot_id = RG_DIG;
      4:       slot_id = RG_CNE;
      default: slot_id = RG_PUE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bitreg.sv
module gpio_bitreg
  import gpio_pkg::*;
#(
  parameter int           W     = 16,
  parameter logic [W-1:0] MASK  = '1,
  parameter logic [W-1:0] RSTV  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  acc_op_t      op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  // R3: masked clear / set / invert; plain write loads
  always_comb begin
    case (op)
      OP_CLR:  nxt = q & ~wdata;
      OP_SET:  nxt = q | wdata;
      OP_INV:  nxt = q ^ wdata;
      default: nxt = wdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RSTV & MASK;
    else if (wr_en) q <= nxt & MASK;  // R9: absent pins never stored
  end
endmodule

// File: rtl/gpio_cn.sv
module gpio_cn #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] arm,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] pend,
  output logic         irq
);
  logic [W-1:0] lvl_d;
  logic [W-1:0] hit;

  assign hit = (lvl ^ lvl_d) & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= '0;
      pend  <= '0;
    end else begin
      lvl_d <= lvl;
      // R10/R11: new event wins over a same-cycle clear
      pend  <= (pend & ~(clr_en ? clr_bits : '0)) | hit;
    end
  end

  assign irq = |pend;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int               NPINS     = 16,
  parameter logic [NPINS-1:0] IMPL_MASK = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [5:0]             addr,
  input  logic [NPINS-1:0]       wdata,
  output logic [NPINS-1:0]       rdata,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       pad_od,
  output logic [NPINS-1:0]       pad_pu,
  output logic                   irq
);
  reg_id_t          sel;
  acc_op_t          op;
  logic [NPINS-1:0] store [NSTORE];
  logic [NPINS-1:0] dir_q, lat_q, ode_q, dig_q, cne_q, pue_q;
  logic [NPINS-1:0] pin_sync, pin_view, pend_q;

  assign sel = reg_id_t'(addr[5:2]);
  assign op  = acc_op_t'(addr[1:0]);

  // R1/R2/R3/R5: one storage register per slot
  for (genvar k = 0; k < NSTORE; k++) begin : g_reg
    localparam reg_id_t ID = slot_id(k);
    localparam logic [NPINS-1:0] RV = (ID == RG_DIR) ? IMPL_MASK : '0;
    logic hit;
    assign hit = we && ((sel == ID) || ((ID == RG_LAT) && (sel == RG_PIN)));
    gpio_bitreg #(.W(NPINS), .MASK(IMPL_MASK), .RSTV(RV)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (hit),
      .op    (op),
      .wdata (wdata),
      .q     (store[k])
    );
  end

  assign dir_q = store[0];
  assign lat_q = store[1];
  assign ode_q = store[2];
  assign dig_q = store[3];
  assign cne_q = store[4];
  assign pue_q = store[5];

  // R6: two-stage input synchronizer
  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in & IMPL_MASK),
    .q     (pin_sync)
  );

  // R7: analog pins read zero
  assign pin_view = pin_sync & dig_q & IMPL_MASK;

  // R10/R11: change notification
  gpio_cn #(.W(NPINS)) u_cn (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (pin_view),
    .arm      (cne_q & dig_q & IMPL_MASK),
    .clr_en   (we && (sel == RG_PEND) && (op == OP_CLR)),
    .clr_bits (wdata),
    .pend     (pend_q),
    .irq      (irq)
  );

  // R2/R4: read mux, aliases read zero
  always_comb begin
    rdata = '0;
    if (op == OP_WR) begin
      case (sel)
        RG_DIR:  rdata = dir_q;
        RG_LAT:  rdata = lat_q;
        RG_PIN:  rdata = pin_view;
        RG_ODE:  rdata = ode_q;
        RG_DIG:  rdata = dig_q;
        RG_CNE:  rdata = cne_q;
        RG_PUE:  rdata = pue_q;
        RG_PEND: rdata = pend_q;
        default: rdata = '0;
      endcase
    end
  end

  // R8/R12: pad drive, open-drain releases high
  assign pad_out = lat_q & ~ode_q;
  assign pad_oe  = ~dir_q & ~(ode_q & lat_q) & IMPL_MASK;
  assign pad_od  = ode_q;
  assign pad_pu  = pue_q;
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int               NPINS     = 16,
  parameter logic [NPINS-1:0] IMPL_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic [5:0]       addr,
  input logic [NPINS-1:0] rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_od,
  input logic [NPINS-1:0] dig_q,
  input logic             irq
);
  p_alias_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> (rdata == '0));

  p_absent_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | pad_od | rdata) & ~IMPL_MASK) == '0);

  p_od_no_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & pad_oe & pad_out) == '0);

  p_analog_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 6'h08) |-> ((rdata & ~dig_q) == '0));

  p_irq_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(we && addr == 6'h1D)) |=> irq);
endmodule

bind gpio_port gpio_port_checker #(.NPINS(NPINS), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .we      (we),
  .addr    (addr),
  .rdata   (rdata),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .pad_od  (pad_od),
  .dig_q   (dig_q),
  .irq     (irq)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam logic [N-1:0] MASK = 16'h3FFF;
  localparam int NVEC = 12;
  // {write addr, write data, read addr, expected read}
  localparam logic [43:0] VEC [NVEC] = '{
    {6'h00, 16'hFFFF, 6'h00, 16'h3FFF},  // R2 R9 absent bits dropped
    {6'h01, 16'h00F0, 6'h00, 16'h3F0F},  // R3 clear
    {6'h02, 16'h0030, 6'h00, 16'h3F3F},  // R3 set
    {6'h03, 16'h0101, 6'h00, 16'h3E3E},  // R3 invert
    {6'h04, 16'h1234, 6'h04, 16'h1234},  // R2 latch
    {6'h08, 16'hC0A5, 6'h04, 16'h00A5},  // R5 port write to latch, R9
    {6'h0A, 16'h0F00, 6'h04, 16'h0FA5},  // R5 port set alias
    {6'h07, 16'h00FF, 6'h04, 16'h0F5A},  // R3 latch invert
    {6'h05, 16'h0F00, 6'h04, 16'h005A},  // R3 latch clear
    {6'h0E, 16'h0003, 6'h0C, 16'h0003},  // R2 open-drain set
    {6'h18, 16'hFFFF, 6'h19, 16'h0000},  // R4 alias read zero
    {6'h10, 16'h8001, 6'h10, 16'h0001}   // R2 digital select, R9
  };

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, irq;
  logic [5:0] addr = '0;
  logic [N-1:0] wdata = '0, pad_in = '0;
  logic [N-1:0] rdata, pad_out, pad_oe, pad_od, pad_pu;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.NPINS(N), .IMPL_MASK(MASK)) u_gpio_port (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_od(pad_od), .pad_pu(pad_pu), .irq(irq)
  );

  task automatic chk(input logic [N-1:0] got, input logic [N-1:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [N-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [N-1:0] exp, input string what);
    addr = a; #1;
    chk(rdata, exp, what);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pad_oe, '0, "R1 pad_oe after reset");
    chk({15'd0, irq}, '0, "R1 irq after reset");
    rd(6'h00, MASK, "R1 direction reset");
    rd(6'h10, '0, "R1 digital select reset");
    rd(6'h04, '0, "R1 latch reset");

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][43:38], VEC[i][37:22]);
      rd(VEC[i][21:16], VEC[i][15:0], $sformatf("R2/R3 table row %0d", i));
    end

    // R12 pull-up and open-drain export
    chk(pad_pu, MASK, "R12 pad_pu");
    chk(pad_od, 16'h0003, "R12 pad_od");

    // R8 output drive and open-drain
    wr(6'h00, 16'h0000);
    wr(6'h04, 16'h00FF);
    wr(6'h0C, 16'h000F);
    #1;
    chk(pad_oe, 16'h3FF0, "R8 oe with open-drain high released");
    chk(pad_out, 16'h00F0, "R8 out with open-drain");
    wr(6'h04, 16'h0000);
    #1;
    chk(pad_oe, 16'h3FFF, "R8 oe driving low");
    chk(pad_out, 16'h0000, "R8 out low");
    wr(6'h00, 16'hFFFF);
    #1;
    chk(pad_oe, 16'h0000, "R8 inputs not driven");

    // R6/R7 synchronized port read, analog bits zero
    wr(6'h10, 16'h00FF);
    @(negedge clk); pad_in = 16'hFFFF; addr = 6'h08;
    @(negedge clk);
    rd(6'h08, 16'h0000, "R6 one edge not yet visible");
    @(negedge clk);
    rd(6'h08, 16'h00FF, "R6 R7 two edges visible, analog zero");

    // R10/R11 change notification
    wr(6'h1D, 16'hFFFF);
    wr(6'h14, 16'h0103);
    @(negedge clk); pad_in = 16'hFFFE;
    @(negedge clk); @(negedge clk);
    chk({15'd0, irq}, '0, "R10 irq not before third edge");
    @(negedge clk);
    chk({15'd0, irq}, 16'h0001, "R10 irq after third edge");
    rd(6'h1C, 16'h0001, "R10 pending bit 0");
    @(negedge clk); pad_in = 16'hFFFA;  // bit 2 not enabled
    repeat (4) @(negedge clk);
    rd(6'h1C, 16'h0001, "R10 disabled pin ignored");
    @(negedge clk); pad_in = 16'hFEFA;  // bit 8 analog
    repeat (4) @(negedge clk);
    rd(6'h1C, 16'h0001, "R10 analog pin ignored");
    chk({15'd0, irq}, 16'h0001, "R10 irq held");
    wr(6'h1D, 16'h0001);
    #1;
    chk({15'd0, irq}, '0, "R11 irq cleared");
    rd(6'h1C, 16'h0000, "R11 pending cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule